// File: doc/BRIEF.md
# Configurable Pad Cell with Output-Enable Selection

This block sits between routed core logic and one three-state pin. A static mode field picks how the cell behaves: a plain combinatorial input, an input captured on an edge of an I/O clock, an input held by a transparent latch, a driven output, or a bidirectional pin. In the bidirectional case the driver enable comes from one of sixteen sources. The two global enables come first, followed by fourteen product-term enables.

Two overrides take priority over the per-cell choice. An active-low test enable turns the driver off. Leaving normal operation through the programming enable also turns the driver off, and that off state persists after the programming enable returns high. Only a global reset applied while the programming enable is high releases it.

The whole cell runs on one system clock. The two dedicated I/O clocks are sampled as level inputs, and the cell acts on their level and on their rising edges. A global reset clears the capture state.

Top module: `io_pad_cell`

## Requirements
- R1: With `cfg_mode` = 0 (combinatorial input), `core_din` equals `pad_in` in the same cycle.
- R2: With `cfg_mode` = 1 (registered input), `core_din` takes the value `pad_in` had at the first system clock edge at which the selected I/O clock is sampled high after being sampled low on the previous edge. `core_din` holds that value at all other times, including while the I/O clock stays high.
- R3: With `cfg_mode` = 2 (latched input), `core_din` follows `pad_in` while the selected I/O clock is high. While that clock is low, `core_din` holds the last `pad_in` value sampled at a system clock edge with the clock high.
- R4: `cfg_clk_sel` = 0 selects `ioclk[0]` and `cfg_clk_sel` = 1 selects `ioclk[1]`. The unselected I/O clock has no effect on `core_din`.
- R5: With `cfg_mode` = 3 (output), and with neither override active, `pad_oe` is 1 and `pad_dout` equals `core_dout`.
- R6: With `cfg_mode` = 4 (bidirectional), and with neither override active, `pad_oe` equals source number `cfg_oe_sel`. Sources 0 and 1 are `goe[0]` and `goe[1]`; source n for n from 2 to 15 is `pt_oe[n-2]`.
- R7: In modes 0, 1 and 2, and in the unused codes 5 to 7, `pad_oe` is 0 whatever `core_dout`, `goe` and `pt_oe` are.
- R8: `pad_dout` equals `core_dout` while `pad_oe` is 1 and is 0 while `pad_oe` is 0.
- R9: While `test_oe_n` is 0, `pad_oe` is 0 in every mode, in the same cycle.
- R10: While `prog_en` is 0, `pad_oe` is 0 in the same cycle. A 1-to-0 transition of `prog_en` sampled on the system clock locks `pad_oe` at 0, and the lock persists after `prog_en` returns to 1.
- R11: The lock is cleared only by a system clock edge at which `rst_n` is 0 and `prog_en` is 1. A reset applied while `prog_en` is 0 leaves the lock in place.
- R12: Asserting `rst_n` low clears the registered-input value and the latch's held value to 0 immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global reset, active low |
| cfg_mode | input | 3 | Cell mode: 0 comb in, 1 registered in, 2 latched in, 3 output, 4 bidirectional |
| cfg_oe_sel | input | 4 | Enable source number for bidirectional mode |
| cfg_clk_sel | input | 1 | Chooses which I/O clock drives capture |
| ioclk | input | 2 | Dedicated I/O clocks, sampled as levels |
| goe | input | 2 | Global output enables |
| pt_oe | input | 14 | Product-term output enables |
| test_oe_n | input | 1 | Test enable, low forces the driver off |
| prog_en | input | 1 | Programming enable, a falling edge locks the driver off |
| core_dout | input | 1 | Data from core logic toward the pin |
| pad_in | input | 1 | Level seen on the pin |
| pad_dout | output | 1 | Data driven to the pin |
| pad_oe | output | 1 | Driver enable for the pin |
| core_din | output | 1 | Data returned to the core logic |

## Verification
On every cycle the assertions check the override gating, the fixed driver states in the input and output modes, the enable source chosen in bidirectional mode, latch transparency, and the register holding between clock rises. They also check that a lock, once set, survives until a reset is taken. The bench scenarios are needed for the remaining behaviour: which data value is captured on a rise, what the latch holds after its clock falls, that the unselected clock has no effect, and that a reset taken with the programming enable low does not release the lock.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  typedef enum logic [2:0] {
    MODE_CIN   = 3'd0,
    MODE_RIN   = 3'd1,
    MODE_LIN   = 3'd2,
    MODE_OUT   = 3'd3,
    MODE_BIDIR = 3'd4
  } iomode_e;

endpackage

// File: rtl/io_capture.sv
module io_capture
  import iocell_pkg::*;
#(
  parameter int NCLK = 2,
  localparam int CSW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  iomode_e         mode,
  input  logic [NCLK-1:0] ioclk,
  input  logic [CSW-1:0]  clk_sel,
  input  logic            pad_in,
  output logic            cap_out
);

  logic [NCLK-1:0] ioclk_q;
  logic            sel_lvl;
  logic            sel_rise;
  logic            reg_q, reg_d;
  logic            hold_q, hold_d;

  assign sel_lvl  = ioclk[clk_sel];
  assign sel_rise = sel_lvl & ~ioclk_q[clk_sel];

  // next-state for edge register and latch hold
  always_comb begin
    reg_d  = reg_q;
    hold_d = hold_q;
    if (mode == MODE_RIN && sel_rise) reg_d  = pad_in;
    if (mode == MODE_LIN && sel_lvl)  hold_d = pad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ioclk_q <= '0;
      reg_q   <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      ioclk_q <= ioclk;
      reg_q   <= reg_d;
      hold_q  <= hold_d;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_RIN: cap_out = reg_q;
      MODE_LIN: cap_out = sel_lvl ? pad_in : hold_q;
      default:  cap_out = pad_in;
    endcase
  end

endmodule

// File: rtl/io_oe_mux.sv
module io_oe_mux #(
  parameter int NGLB = 2,
  parameter int NPT  = 14,
  localparam int NSRC = NGLB + NPT,
  localparam int SW   = $clog2(NSRC)
) (
  input  logic [NGLB-1:0] goe,
  input  logic [NPT-1:0]  pt_oe,
  input  logic [SW-1:0]   sel,
  output logic            oe_src
);

  logic [NSRC-1:0] src;

  // global enables occupy the low source numbers
  for (genvar g = 0; g < NGLB; g++) begin : g_glb
    assign src[g] = goe[g];
  end
  for (genvar p = 0; p < NPT; p++) begin : g_pt
    assign src[NGLB+p] = pt_oe[p];
  end

  always_comb begin
    oe_src = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SW'(i)) oe_src = src[i];
    end
  end

endmodule

// File: rtl/io_hiz_guard.sv
module io_hiz_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_en,
  input  logic test_oe_n,
  output logic prog_lock,
  output logic force_hiz
);

  logic prog_q;
  logic lock_q, lock_d;

  // the lock is kept out of the asynchronous reset on purpose:
  // reset may only clear it when the programming enable is high
  always_comb begin
    if (!rst_n && prog_en)        lock_d = 1'b0;
    else if (prog_q && !prog_en)  lock_d = 1'b1;
    else                          lock_d = lock_q;
  end

  always_ff @(posedge clk) begin
    prog_q <= prog_en;
    lock_q <= lock_d;
  end

  assign prog_lock = lock_q;
  assign force_hiz = ~test_oe_n | ~prog_en | lock_q;

endmodule

// File: rtl/io_pad_cell.sv
module io_pad_cell
  import iocell_pkg::*;
#(
  parameter int NCLK = 2,
  parameter int NGLB = 2,
  parameter int NPT  = 14,
  localparam int CSW = (NCLK > 1) ? $clog2(NCLK) : 1,
  localparam int SW  = $clog2(NGLB + NPT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cfg_mode,
  input  logic [SW-1:0]   cfg_oe_sel,
  input  logic [CSW-1:0]  cfg_clk_sel,
  input  logic [NCLK-1:0] ioclk,
  input  logic [NGLB-1:0] goe,
  input  logic [NPT-1:0]  pt_oe,
  input  logic            test_oe_n,
  input  logic            prog_en,
  input  logic            core_dout,
  input  logic            pad_in,
  output logic            pad_dout,
  output logic            pad_oe,
  output logic            core_din
);

  iomode_e mode;
  logic    oe_src;
  logic    oe_raw;
  logic    prog_lock;
  logic    force_hiz;

  assign mode = iomode_e'(cfg_mode);

  io_capture #(.NCLK(NCLK)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .ioclk   (ioclk),
    .clk_sel (cfg_clk_sel),
    .pad_in  (pad_in),
    .cap_out (core_din)
  );

  io_oe_mux #(.NGLB(NGLB), .NPT(NPT)) u_oe (
    .goe    (goe),
    .pt_oe  (pt_oe),
    .sel    (cfg_oe_sel),
    .oe_src (oe_src)
  );

  io_hiz_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (prog_en),
    .test_oe_n (test_oe_n),
    .prog_lock (prog_lock),
    .force_hiz (force_hiz)
  );

  always_comb begin
    unique case (mode)
      MODE_OUT:   oe_raw = 1'b1;
      MODE_BIDIR: oe_raw = oe_src;
      default:    oe_raw = 1'b0;
    endcase
  end

  assign pad_oe   = oe_raw & ~force_hiz;
  assign pad_dout = pad_oe & core_dout;

endmodule

// File: rtl/io_pad_cell_chk.sv
module io_pad_cell_chk #(
  parameter int NCLK = 2,
  parameter int NGLB = 2,
  parameter int NPT  = 14,
  localparam int CSW = (NCLK > 1) ? $clog2(NCLK) : 1,
  localparam int SW  = $clog2(NGLB + NPT)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      cfg_mode,
  input logic [SW-1:0]   cfg_oe_sel,
  input logic [CSW-1:0]  cfg_clk_sel,
  input logic [NCLK-1:0] ioclk,
  input logic [NGLB-1:0] goe,
  input logic [NPT-1:0]  pt_oe,
  input logic            test_oe_n,
  input logic            prog_en,
  input logic            core_dout,
  input logic            pad_in,
  input logic            pad_dout,
  input logic            pad_oe,
  input logic            core_din,
  input logic            prog_lock
);

  logic [NCLK-1:0]      clk_prev;
  logic [NGLB+NPT-1:0]  src_vec;
  logic                 no_ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= '0;
    else        clk_prev <= ioclk;
  end

  assign src_vec = {pt_oe, goe};
  assign no_ovr  = test_oe_n && prog_en && !prog_lock;

  // R1
  comb_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd0) |-> (core_din == pad_in));

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd1 && !(ioclk[cfg_clk_sel] && !clk_prev[cfg_clk_sel]))
      |=> (cfg_mode != 3'd1 || $stable(core_din)));

  // R3
  latch_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd2 && ioclk[cfg_clk_sel]) |-> (core_din == pad_in));

  // R5
  out_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd3 && no_ovr) |-> (pad_oe && pad_dout == core_dout));

  // R6
  bidir_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd4 && no_ovr) |-> (pad_oe == src_vec[cfg_oe_sel]));

  // R7
  in_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 3'd3 && cfg_mode != 3'd4) |-> !pad_oe);

  // R8
  dout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> !pad_dout);

  // R9
  test_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_oe_n |-> !pad_oe);

  // R10
  prog_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |-> !pad_oe);

  // R11
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(prog_lock)) |-> prog_lock);

endmodule

bind io_pad_cell io_pad_cell_chk #(.NCLK(NCLK), .NGLB(NGLB), .NPT(NPT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_mode    (cfg_mode),
  .cfg_oe_sel  (cfg_oe_sel),
  .cfg_clk_sel (cfg_clk_sel),
  .ioclk       (ioclk),
  .goe         (goe),
  .pt_oe       (pt_oe),
  .test_oe_n   (test_oe_n),
  .prog_en     (prog_en),
  .core_dout   (core_dout),
  .pad_in      (pad_in),
  .pad_dout    (pad_dout),
  .pad_oe      (pad_oe),
  .core_din    (core_din),
  .prog_lock   (prog_lock)
);

// File: tb/sim_io_pad_cell.sv
module sim_io_pad_cell;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_mode;
  logic [3:0]  cfg_oe_sel;
  logic [0:0]  cfg_clk_sel;
  logic [1:0]  ioclk;
  logic [1:0]  goe;
  logic [13:0] pt_oe;
  logic        test_oe_n;
  logic        prog_en;
  logic        core_dout;
  logic        pad_in;
  logic        pad_dout;
  logic        pad_oe;
  logic        core_din;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  io_pad_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_oe_sel(cfg_oe_sel),
    .cfg_clk_sel(cfg_clk_sel), .ioclk(ioclk), .goe(goe), .pt_oe(pt_oe),
    .test_oe_n(test_oe_n), .prog_en(prog_en), .core_dout(core_dout),
    .pad_in(pad_in), .pad_dout(pad_dout), .pad_oe(pad_oe), .core_din(core_din)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_mode = 3'd0; cfg_oe_sel = 4'd0; cfg_clk_sel = 1'b0;
    ioclk = 2'b00; goe = 2'b00; pt_oe = '0; test_oe_n = 1'b1; prog_en = 1'b1;
    core_dout = 1'b0; pad_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 reset state oe", pad_oe, 1'b0);
    chk("R1 reset state din", core_din, 1'b0);
    rst_n = 1'b1;
    cfg_mode = 3'd1; #1;
    chk("R12 reg cleared after reset", core_din, 1'b0);
    cfg_mode = 3'd0;

    // R1 combinatorial input
    for (int v = 0; v < 2; v++) begin
      @(negedge clk); pad_in = v[0]; #1;
      chk("R1 comb input", core_din, v[0]);
    end

    // R7 input and unused modes never drive
    core_dout = 1'b1; goe = 2'b11; pt_oe = '1;
    for (int m = 0; m < 8; m++) begin
      if (m == 3 || m == 4) continue;
      @(negedge clk); cfg_mode = 3'(m); #1;
      chk("R7 driver off", pad_oe, 1'b0);
      chk("R8 dout gated", pad_dout, 1'b0);
    end
    goe = 2'b00; pt_oe = '0;

    // R5 output mode
    for (int v = 0; v < 2; v++) begin
      @(negedge clk); cfg_mode = 3'd3; core_dout = v[0]; #1;
      chk("R5 output oe", pad_oe, 1'b1);
      chk("R5 output data", pad_dout, v[0]);
    end

    // R6 / R8 bidirectional enable sweep, one-hot source patterns
    cfg_mode = 3'd4; core_dout = 1'b1;
    for (int s = 0; s < 16; s++) begin
      cfg_oe_sel = 4'(s);
      for (int k = 0; k < 16; k++) begin
        goe = '0; pt_oe = '0;
        if (k < 2) goe[k] = 1'b1; else pt_oe[k-2] = 1'b1;
        #1;
        chk("R6 bidir enable select", pad_oe, (k == s));
        chk("R8 bidir data gate", pad_dout, (k == s));
      end
      goe = '1; pt_oe = '1;
      if (s < 2) goe[s] = 1'b0; else pt_oe[s-2] = 1'b0;
      #1;
      chk("R6 bidir selected low", pad_oe, 1'b0);
    end
    goe = '0; pt_oe = '0;

    // R2 / R4 registered input on each clock
    for (int s = 0; s < 2; s++) begin
      @(negedge clk); cfg_mode = 3'd1; cfg_clk_sel = 1'(s); ioclk = 2'b00; pad_in = 1'b1;
      @(negedge clk); ioclk[1-s] = 1'b1;
      @(negedge clk); chk("R4 other clock ignored (reg)", core_din, 1'b0);
      ioclk = 2'b00;
      @(negedge clk); ioclk[s] = 1'b1;
      @(negedge clk); chk("R2 captured on rise", core_din, 1'b1);
      pad_in = 1'b0;
      @(negedge clk); chk("R2 held while clock high", core_din, 1'b1);
      ioclk = 2'b00;
      @(negedge clk); chk("R2 held while clock low", core_din, 1'b1);
      ioclk[s] = 1'b1;
      @(negedge clk); chk("R2 second capture", core_din, 1'b0);
      ioclk = 2'b00;
    end

    // R3 / R4 latched input on each clock
    for (int s = 0; s < 2; s++) begin
      @(negedge clk); cfg_mode = 3'd2; cfg_clk_sel = 1'(s); ioclk = 2'b00; pad_in = 1'b0;
      @(negedge clk); ioclk[s] = 1'b1; pad_in = 1'b1; #1;
      chk("R3 transparent high", core_din, 1'b1);
      pad_in = 1'b0; #1;
      chk("R3 transparent follow", core_din, 1'b0);
      pad_in = 1'b1;
      @(negedge clk); ioclk[s] = 1'b0; pad_in = 1'b0; #1;
      chk("R3 holds when low", core_din, 1'b1);
      ioclk[1-s] = 1'b1; #1;
      chk("R4 other clock ignored (latch)", core_din, 1'b1);
      @(negedge clk); chk("R4 other clock held", core_din, 1'b1);
      ioclk = 2'b00;
    end

    // R12 reset clears captured state
    @(negedge clk); cfg_mode = 3'd1; cfg_clk_sel = 1'b0; pad_in = 1'b1; ioclk = 2'b01;
    @(negedge clk); chk("R2 capture before reset", core_din, 1'b1);
    ioclk = 2'b00; pad_in = 1'b0;
    rst_n = 1'b0; #1;
    chk("R12 reg cleared", core_din, 1'b0);
    cfg_mode = 3'd2; #1;
    chk("R12 latch cleared", core_din, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R9 test enable override
    @(negedge clk); cfg_mode = 3'd3; core_dout = 1'b1; #1;
    chk("R5 drive before test", pad_oe, 1'b1);
    test_oe_n = 1'b0; #1;
    chk("R9 test forces off", pad_oe, 1'b0);
    chk("R8 data gated in test", pad_dout, 1'b0);
    cfg_mode = 3'd4; goe = 2'b01; cfg_oe_sel = 4'd0; #1;
    chk("R9 test forces off bidir", pad_oe, 1'b0);
    test_oe_n = 1'b1; cfg_mode = 3'd3; #1;
    chk("R9 release test", pad_oe, 1'b1);

    // R10 / R11 programming lock
    @(negedge clk); prog_en = 1'b0; #1;
    chk("R10 immediate off", pad_oe, 1'b0);
    @(negedge clk); prog_en = 1'b1; #1;
    chk("R10 locked after rise", pad_oe, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 lock persists", pad_oe, 1'b0);
    prog_en = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); prog_en = 1'b1;
    @(negedge clk);
    chk("R11 reset with prog low keeps lock", pad_oe, 1'b0);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset with prog high releases", pad_oe, 1'b1);
    chk("R5 drive after release", pad_dout, 1'b1);

    finish_run();
  end

endmodule